// File: doc/BRIEF.md
# Wake Clock Switchover Controller

This block decides which oscillator times the system as it leaves stop mode. While stop is requested, the crystal oscillator is switched off and the system clock enable is held quiet. When stop ends, the crystal is switched back on and a start-up counter counts crystal ticks. The wake policy is sampled at the moment stop ends, and there are two policies. Under the first, execution holds until the count completes. Under the second, execution resumes at once on a fast internal ring oscillator, and the block then hands the system over to the crystal.

Both oscillators are modelled as single-cycle tick enables on one fast reference clock. The handover is break-before-make. Once the start-up count completes, ring ticks stop reaching the system. A short run of further crystal ticks lets both sources settle. Only then are crystal ticks forwarded, so a ring tick and a crystal tick can never merge into a short pulse. While the ring is the active source, the clock-divide code sent to the divider is forced to divide-by-1. The watchdog tick is taken from the crystal alone.

Top module: `wclk_switch`

## Requirements
- R1: After reset the crystal is on, the ring is off, the status bit reads 0, execution runs, and the system tick follows the crystal tick.
- R2: In every cycle after a cycle in which stop was requested, the crystal enable, the system tick and the run output are all 0. Crystal ticks that arrive in that state are ignored.
- R3: With the wake policy bit at 0 when stop ends, the run output stays 0 and the system tick stays 0 until exactly STARTUP_CYCLES crystal ticks have arrived after the wake edge. In the next cycle, execution runs on the crystal.
- R4: With the wake policy bit at 1 when stop ends, execution runs at once and the system tick equals the ring tick until the STARTUP_CYCLES-th crystal tick.
- R5: The status output reads 1 from the wake edge until the switch to the crystal under the ring policy. It reads 0 at all other times.
- R6: After the start-up count completes under the ring policy, the system tick is 0 for the next SYNC_STAGES crystal ticks. Only after those ticks is the crystal tick forwarded.
- R7: While the status bit is 1, the divider code output is the lock code 2'b10. Otherwise it equals the requested divide code.
- R8: The ring enable output is 1 only while the status bit is 1, so the ring is off once the crystal has taken over.
- R9: The watchdog tick equals the crystal tick whenever the crystal is enabled, is 0 while it is disabled, and never follows the ring tick.
- R10: If stop is requested again before the start-up count completes, the count starts over from zero at the next wake.
- R11: The wake policy bit is sampled only in the cycle in which stop ends. Changing it later in the wake sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | High while stop mode is requested |
| ring_sel_en | input | 1 | Wake policy: 1 runs from ring at once, 0 holds until crystal is stable |
| xtal_tick | input | 1 | Crystal oscillator tick enable |
| ring_tick | input | 1 | Ring oscillator tick enable |
| div_req | input | DIV_W | Requested clock-divide code |
| sys_tick | output | 1 | System clock tick enable |
| wdog_tick | output | 1 | Watchdog tick, from the crystal only |
| xtal_on | output | 1 | Crystal oscillator enable |
| ring_on | output | 1 | Ring oscillator enable |
| ring_active | output | 1 | Status: ring is the system clock source |
| cpu_run | output | 1 | 1 lets instruction execution proceed |
| div_eff | output | DIV_W | Divide code delivered to the clock divider |

## Verification
The hardest case to reach from the ports is a wake sequence that is cut off by a new stop request part-way through the start-up count. This case shows whether the count really restarts. It needs exact control of how many crystal ticks fall inside the wake window. The bench sweeps both policies, several crystal and ring tick spacings, and aborted and clean wakes. In every cycle it compares all outputs against an arithmetic model that counts the crystal ticks it has itself driven. It also toggles the policy bit during the wake sequence to show that only the value at the wake edge matters.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
   typedef enum logic [1:0] {
      WS_RUN  = 2'd0,
      WS_STOP = 2'd1,
      WS_WARM = 2'd2,
      WS_HAND = 2'd3
   } wclk_state_t;
endpackage

// File: rtl/wclk_tick_cnt.sv
module wclk_tick_cnt #(
   parameter int unsigned LIMIT = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic done
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("wclk_tick_cnt: LIMIT must be at least 2");
   end

   localparam int unsigned CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign done = en && !clr && (cnt == LAST);

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/wclk_src_sel.sv
module wclk_src_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic use_xtal,
   input  logic use_ring,
   input  logic xtal_tick,
   input  logic ring_tick,
   output logic sys_tick
);
   assign sys_tick = (use_xtal && xtal_tick) || (use_ring && ring_tick);

   // R6
   src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({use_xtal, use_ring}));
endmodule

// File: rtl/wclk_div_lock.sv
module wclk_div_lock #(
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned LOCK_CODE = 2
) (
   input  logic             lock,
   input  logic [DIV_W-1:0] div_req,
   output logic [DIV_W-1:0] div_eff
);
   if (DIV_W < 1 || LOCK_CODE >= (1 << DIV_W)) begin : g_bad_code
      $error("wclk_div_lock: LOCK_CODE does not fit in DIV_W bits");
   end

   localparam logic [DIV_W-1:0] LOCK_VAL = DIV_W'(LOCK_CODE);

   assign div_eff = lock ? LOCK_VAL : div_req;
endmodule

// File: rtl/wclk_switch.sv
module wclk_switch
   import wclk_pkg::*;
#(
   parameter int unsigned STARTUP_CYCLES = 65536,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DIV_W          = 2,
   parameter int unsigned DIV_LOCK_CODE  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic             ring_sel_en,
   input  logic             xtal_tick,
   input  logic             ring_tick,
   input  logic [DIV_W-1:0] div_req,
   output logic             sys_tick,
   output logic             wdog_tick,
   output logic             xtal_on,
   output logic             ring_on,
   output logic             ring_active,
   output logic             cpu_run,
   output logic [DIV_W-1:0] div_eff
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 16) begin : g_bad_sync
      $error("wclk_switch: SYNC_STAGES must be in 2..16");
   end

   wclk_state_t state, state_nx;
   logic        mode_ring;
   logic        warm_done, hand_done;
   logic        in_stop, in_warm, in_hand, in_run;

   assign in_stop = (state == WS_STOP);
   assign in_warm = (state == WS_WARM);
   assign in_hand = (state == WS_HAND);
   assign in_run  = (state == WS_RUN);

   wclk_tick_cnt #(.LIMIT(STARTUP_CYCLES)) u_warm_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (in_stop),
      .en   (in_warm && xtal_tick),
      .done (warm_done)
   );

   wclk_tick_cnt #(.LIMIT(SYNC_STAGES)) u_hand_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (in_stop),
      .en   (in_hand && xtal_tick),
      .done (hand_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         WS_RUN:  if (stop_req) state_nx = WS_STOP;
         WS_STOP: if (!stop_req) state_nx = WS_WARM;
         WS_WARM: begin
            if (stop_req)       state_nx = WS_STOP;
            else if (warm_done) state_nx = mode_ring ? WS_HAND : WS_RUN;
         end
         WS_HAND: begin
            if (stop_req)       state_nx = WS_STOP;
            else if (hand_done) state_nx = WS_RUN;
         end
         default: state_nx = WS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= WS_RUN;
         mode_ring <= 1'b0;
      end else begin
         state <= state_nx;
         if (in_stop && !stop_req) begin
            mode_ring <= ring_sel_en;
         end
      end
   end

   assign xtal_on     = !in_stop;
   assign ring_active = (in_warm || in_hand) && mode_ring;
   assign ring_on     = ring_active;
   assign cpu_run     = in_run || ring_active;
   assign wdog_tick   = xtal_tick && xtal_on;

   wclk_src_sel u_src_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_xtal (in_run),
      .use_ring (in_warm && mode_ring),
      .xtal_tick(xtal_tick),
      .ring_tick(ring_tick),
      .sys_tick (sys_tick)
   );

   wclk_div_lock #(.DIV_W(DIV_W), .LOCK_CODE(DIV_LOCK_CODE)) u_div_lock (
      .lock   (ring_active),
      .div_req(div_req),
      .div_eff(div_eff)
   );

   // R2
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (!xtal_on && !sys_tick && !cpu_run));

   // R3
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_run |-> !sys_tick);

   // R6
   break_before_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ring_active) && !$past(stop_req)) |-> !$past(sys_tick));

   // R5
   ring_needs_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_active |-> xtal_on);
endmodule

// File: tb/wclk_switch_tb.sv
module wclk_switch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int STARTUP    = 20;
   localparam int SYNC       = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 1'b0;
   logic       ring_sel_en = 1'b0;
   logic       xtal_tick = 1'b0;
   logic       ring_tick = 1'b0;
   logic [1:0] div_req = 2'b00;
   logic       sys_tick, wdog_tick, xtal_on, ring_on, ring_active, cpu_run;
   logic [1:0] div_eff;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int ms = 0;
   int mmode = 0;
   int mwc = 0;
   int mhc = 0;
   int cyc = 0;
   int hold_ticks = 0;
   bit hold_seen = 1'b0;
   bit aborted = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wclk_switch #(
      .STARTUP_CYCLES(STARTUP),
      .SYNC_STAGES   (SYNC),
      .DIV_W         (2),
      .DIV_LOCK_CODE (2)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req),
      .ring_sel_en(ring_sel_en),
      .xtal_tick  (xtal_tick),
      .ring_tick  (ring_tick),
      .div_req    (div_req),
      .sys_tick   (sys_tick),
      .wdog_tick  (wdog_tick),
      .xtal_on    (xtal_on),
      .ring_on    (ring_on),
      .ring_active(ring_active),
      .cpu_run    (cpu_run),
      .div_eff    (div_eff)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic step(input bit stp, input bit sel, input bit xt, input bit rt);
      int e_xon, e_ring, e_run, e_sys, e_wd, e_div;
      string sys_tag;
      @(negedge clk);
      stop_req    = stp;
      ring_sel_en = sel;
      xtal_tick   = xt;
      ring_tick   = rt;
      div_req     = 2'(cyc % 4);
      #1;
      e_xon  = (ms != 1) ? 1 : 0;
      e_ring = ((ms == 2 || ms == 3) && mmode == 1) ? 1 : 0;
      e_run  = (ms == 0 || e_ring == 1) ? 1 : 0;
      if (ms == 0)                     e_sys = int'(xt);
      else if (ms == 2 && mmode == 1)  e_sys = int'(rt);
      else                             e_sys = 0;
      e_wd   = (xt && e_xon == 1) ? 1 : 0;
      e_div  = (e_ring == 1) ? 2 : cyc % 4;
      if (ms == 1)                           sys_tag = "R2";
      else if (ms == 3)                      sys_tag = "R6";
      else if (ms == 2 && int'(sel) != mmode) sys_tag = "R11";
      else if (ms == 2 && mmode == 1)        sys_tag = "R4";
      else if (ms == 2)                      sys_tag = "R3";
      else                                   sys_tag = "R8";
      chk(int'(xtal_on) == e_xon, "R2 xtal_on", int'(xtal_on), e_xon);
      chk(int'(sys_tick) == e_sys, sys_tag, int'(sys_tick), e_sys);
      chk(int'(cpu_run) == e_run, "R3 cpu_run", int'(cpu_run), e_run);
      chk(int'(ring_active) == e_ring, "R5 ring_active", int'(ring_active), e_ring);
      chk(int'(ring_on) == e_ring, "R8 ring_on", int'(ring_on), e_ring);
      chk(int'(wdog_tick) == e_wd, "R9 wdog_tick", int'(wdog_tick), e_wd);
      chk(int'(div_eff) == e_div, "R7 div_eff", int'(div_eff), e_div);
      // hold-policy tick tally seen at the ports (R3, R10)
      if (!xtal_on) begin
         hold_ticks = 0;
         hold_seen  = 1'b0;
      end else if (!cpu_run) begin
         hold_seen = 1'b1;
         if (xt) hold_ticks++;
      end else if (hold_seen) begin
         chk(hold_ticks == STARTUP, aborted ? "R10 restart count" : "R3 hold count",
             hold_ticks, STARTUP);
         hold_seen  = 1'b0;
         hold_ticks = 0;
      end
      // model update at the coming edge
      case (ms)
         0: if (stp) ms = 1;
         1: if (!stp) begin ms = 2; mmode = int'(sel); mwc = 0; mhc = 0; end
         2: if (stp) ms = 1;
            else if (xt) begin
               mwc++;
               if (mwc == STARTUP) begin ms = (mmode == 1) ? 3 : 0; mwc = 0; end
            end
         default: if (stp) ms = 1;
            else if (xt) begin
               mhc++;
               if (mhc == SYNC) begin ms = 0; mhc = 0; end
            end
      endcase
      cyc++;
   endtask

   task automatic scenario(input bit mode, input int p, input int q, input bit abort);
      aborted = abort;
      for (int i = 0; i < 3; i++) step(1'b0, mode, (cyc % p) == 0, (cyc % q) == 0);
      for (int i = 0; i < 4; i++) step(1'b1, mode, (cyc % p) == 0, (cyc % q) == 0);
      if (abort) begin
         for (int i = 0; i < 7 * p; i++)
            step(1'b0, (i == 0) ? mode : ((cyc % 3) != 0) ^ mode, (cyc % p) == 0, (cyc % q) == 0);
         for (int i = 0; i < 3; i++) step(1'b1, mode, (cyc % p) == 0, (cyc % q) == 0);
      end
      for (int i = 0; i < (STARTUP + SYNC + 4) * p + 10; i++)
         step(1'b0, (i == 0) ? mode : ((cyc % 3) != 0) ^ mode, (cyc % p) == 0, (cyc % q) == 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 3 + 2);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      xtal_tick = 1'b1;
      div_req   = 2'b01;
      #1;
      chk(xtal_on == 1'b1, "R1 xtal_on", int'(xtal_on), 1);
      chk(ring_on == 1'b0, "R1 ring_on", int'(ring_on), 0);
      chk(ring_active == 1'b0, "R1 ring_active", int'(ring_active), 0);
      chk(cpu_run == 1'b1, "R1 cpu_run", int'(cpu_run), 1);
      chk(sys_tick == 1'b1, "R1 sys_tick", int'(sys_tick), 1);
      chk(div_eff == 2'b01, "R1 div_eff", int'(div_eff), 1);
      for (int m = 0; m < 2; m++)
         for (int p = 1; p <= 4; p++)
            for (int q = 1; q <= 2; q++)
               for (int a = 0; a < 2; a++)
                  scenario(m[0], p, q, a[0]);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule